// File: doc/BRIEF.md
# Branch-Capable Instruction Fetch Unit

This block keeps the program counter of a single-cycle processor and chooses its next value on every clock. The current PC addresses a small instruction store, and the word held there comes back combinationally as the instruction of the current cycle. Every instruction is fetched the same way.

The next PC is normally the current PC plus four. A conditional branch is taken only when the branch-select control and the ALU zero flag are both high. In that case the next PC is PC plus four plus the 16-bit offset, which is first sign-extended and then shifted left by two. The testbench fills the instruction store through a write port. Reset is synchronous and active low, and it clears the PC to zero.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 on that edge.
- R2: `instr` always equals the store word at index `pc[ADDR_BITS+1:2]`. The store is word-addressed, so byte address 4*k maps to word k.
- R3: When `br_sel` is 0, the next PC is PC+4, whatever the value of `alu_zero`.
- R4: When `br_sel` is 1 and `alu_zero` is 0, the next PC is PC+4.
- R5: When `br_sel` and `alu_zero` are both 1, the next PC is PC+4+(sign-extended `imm16` shifted left by 2). An `imm16` with bit 15 set gives a backward target.
- R6: PC bits [1:0] are 0 at all times.
- R7: All PC arithmetic wraps modulo 2^32.
- R8: A write on port `wr_en`/`wr_addr`/`wr_data` updates word `wr_addr` of the store at the rising edge. The new word is visible on `instr` from the next cycle onward.
- R9: `pc` and `imem_addr` carry the same value, which is the byte address of the current fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_sel | input | 1 | Branch-select control |
| alu_zero | input | 1 | ALU zero flag |
| imm16 | input | 16 | Branch offset in words |
| wr_en | input | 1 | Instruction store write enable |
| wr_addr | input | ADDR_BITS | Instruction store word index to write |
| wr_data | input | 32 | Word to write |
| instr | output | 32 | Fetched instruction |
| pc | output | 32 | Current program counter |
| imem_addr | output | 32 | Byte address given to the instruction store |

## Verification
The bench sweeps all four combinations of `br_sel` and `alu_zero`. A design that wrongly ORed the two signals, or ignored zero, would take branches it should skip. Offsets 0x7FFF, 0x8000, 0xFFFF and 0 exercise the sign extension. Missing extension would jump forward about 256 KB instead of backward, and a missing shift by two would land on a misaligned PC. PCs near 0xFFFFFFFC check wraparound. Reading every store word after the write phase catches address slicing that uses `pc[ADDR_BITS-1:0]` in place of the word index.

// File: rtl/fetch_pkg.sv
// Package: shared widths and helpers for the instruction fetch unit.
// Assumes 32-bit words and byte addressing.
package fetch_pkg;
    localparam int XLEN = 32;
    localparam int IMM_W = 16;
    typedef logic [XLEN-1:0] word_t;

    // Sign-extend a branch offset and convert words to bytes.
    function automatic word_t branch_offset(input logic [IMM_W-1:0] imm);
        word_t ext;
        ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return {ext[XLEN-3:0], 2'b00};
    endfunction
endpackage

// File: rtl/fetch_next_pc.sv
// Next-PC logic: computes PC+4 and the branch target, and picks one of them.
// Assumes a combinational path only. The select is br_sel AND zero.
module fetch_next_pc
    import fetch_pkg::*;
(
    input  word_t            pc_cur,
    input  logic             br_sel,
    input  logic             alu_zero,
    input  logic [IMM_W-1:0] imm16,
    output word_t            pc_next
);
    word_t seq_pc;
    word_t tgt_pc;
    logic  take;

    // Compute both candidates and the select.
    always_comb begin
        seq_pc  = pc_cur + word_t'(4);
        tgt_pc  = seq_pc + branch_offset(imm16);
        take    = br_sel & alu_zero;
        pc_next = take ? tgt_pc : seq_pc;
    end
endmodule

// File: rtl/fetch_pc_reg.sv
// Program-counter register with synchronous active-low reset to zero.
// Assumes the next value is already word-aligned.
module fetch_pc_reg
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t pc_next,
    output word_t pc_q
);
    // Register the PC on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end
endmodule

// File: rtl/fetch_imem.sv
// Word-addressed instruction store: combinational read, synchronous write.
// Assumes the caller passes the word index, not the byte address.
module fetch_imem
    import fetch_pkg::*;
#(
    parameter int ADDR_BITS = 6
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  word_t                wr_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output word_t                rd_data
);
    localparam int DEPTH = 1 << ADDR_BITS;
    word_t mem [DEPTH];

    // Write port: load a word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read port: fetch the addressed word.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/fetch_unit.sv
// Top of the instruction fetch unit: PC register, next-PC select and store.
// Assumes a store of 2**ADDR_BITS words; upper PC bits alias.
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int ADDR_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 br_sel,
    input  logic                 alu_zero,
    input  logic [15:0]          imm16,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [31:0]          wr_data,
    output logic [31:0]          instr,
    output logic [31:0]          pc,
    output logic [31:0]          imem_addr
);
    word_t pc_q;
    word_t pc_nx;

    fetch_pc_reg u_pc (.clk(clk), .rst_n(rst_n), .pc_next(pc_nx), .pc_q(pc_q));

    fetch_next_pc u_nx (.pc_cur(pc_q), .br_sel(br_sel), .alu_zero(alu_zero),
                        .imm16(imm16), .pc_next(pc_nx));

    fetch_imem #(.ADDR_BITS(ADDR_BITS)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(pc_q[ADDR_BITS+1:2]), .rd_data(instr));

    // Drive the visible addresses.
    always_comb begin
        pc        = pc_q;
        imem_addr = pc_q;
    end
endmodule

// File: rtl/fetch_unit_chk.sv
// Checker for fetch_unit, attached through bind.
module fetch_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        br_sel,
    input logic        alu_zero,
    input logic [15:0] imm16,
    input logic [31:0] pc,
    input logic [31:0] imem_addr
);
    logic seen;
    always_ff @(posedge clk) seen <= 1'b1;

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> pc == 32'd0); // R1
    AST_SEQ_NO_BR: assert property (@(posedge clk) disable iff (!rst_n)
        !br_sel |=> pc == $past(pc) + 32'd4); // R3
    AST_SEQ_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && !alu_zero) |=> pc == $past(pc) + 32'd4); // R4
    AST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && alu_zero) |=> pc == $past(pc) + 32'd4 +
            {{14{$past(imm16[15])}}, $past(imm16), 2'b00}); // R5
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> pc[1:0] == 2'b00); // R6
    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> imem_addr == pc); // R9
endmodule

bind fetch_unit fetch_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .br_sel(br_sel), .alu_zero(alu_zero),
    .imm16(imm16), .pc(pc), .imem_addr(imem_addr));

// File: tb/test_fetch_unit.sv
module test_fetch_unit;
    localparam int AB = 4;
    localparam int DEPTH = 1 << AB;

    logic clk = 0, rst_n = 0, br_sel = 0, alu_zero = 0, wr_en = 0;
    logic [15:0] imm16 = 0;
    logic [AB-1:0] wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] instr, pc, imem_addr;
    int errors = 0, checks = 0;
    logic [31:0] exp_pc;

    fetch_unit #(.ADDR_BITS(AB)) i_fetch_unit (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] word_at(input int k);
        return 32'hA5000000 ^ (k * 32'h01010101);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic b, input logic z, input logic [15:0] im);
        br_sel = b; alu_zero = z; imm16 = im;
        exp_pc = pc + 32'd4 + ((b && z) ? {{14{im[15]}}, im, 2'b00} : 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic reset_pc();
        rst_n = 0; br_sel = 0; alu_zero = 0;
        @(posedge clk); #1;
        check("R1", pc, 32'd0);
        rst_n = 1;
    endtask

    initial begin
        #150000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        // R8: load every word of the store
        wr_en = 1;
        for (int k = 0; k < DEPTH; k++) begin
            wr_addr = AB'(k); wr_data = word_at(k);
            @(posedge clk); #1;
        end
        wr_en = 0;
        reset_pc();
        check("R9", imem_addr, 32'd0);
        // R2 R8: sequential walk reads every word
        for (int k = 0; k < DEPTH; k++) begin
            check("R2", instr, word_at(k));
            check("R9", imem_addr, pc);
            step(0, 0, 16'h0);
            check("R3", pc, exp_pc);
        end
        // R3 R4 R5: all select combinations over several offsets
        begin
            logic [15:0] offs [5];
            offs = '{16'h0000, 16'h0003, 16'hFFFF, 16'h8000, 16'h7FFF};
            for (int o = 0; o < 5; o++) begin
                for (int c = 0; c < 4; c++) begin
                    step(c[1], c[0], offs[o]);
                    if (c == 3) check("R5", pc, exp_pc);
                    else if (c[1]) check("R4", pc, exp_pc);
                    else check("R3", pc, exp_pc);
                    check("R6", {30'd0, pc[1:0]}, 32'd0);
                    check("R2", instr, word_at(int'(pc[AB+1:2])));
                end
            end
        end
        // R5: backward branch of one word goes back to the same fetch address
        reset_pc();
        step(1, 1, 16'hFFFF);
        check("R5", pc, 32'd0);
        // R7: wrap below zero
        step(1, 1, 16'hFFFD);
        check("R7", pc, 32'hFFFFFFF8);
        step(0, 0, 0);
        check("R7", pc, 32'hFFFFFFFC);
        step(0, 1, 0);
        check("R7", pc, 32'h00000000);
        check("R2", instr, word_at(0));
        // R8: overwrite word 1 and confirm the next fetch sees it
        wr_en = 1; wr_addr = 1; wr_data = 32'hDEADBEEF;
        @(posedge clk); #1;
        wr_en = 0;
        reset_pc();
        step(0, 0, 0);
        check("R8", instr, 32'hDEADBEEF);
        // R1: reset in the middle of a run wins over a taken branch
        step(1, 1, 16'h0010);
        rst_n = 0; br_sel = 1; alu_zero = 1;
        @(posedge clk); #1;
        check("R1", pc, 32'd0);
        rst_n = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule